// File: doc/BRIEF.md
# Receive CRC checker with automatic reinitialisation

This block keeps a running 16-bit CCITT CRC over the bits of a synchronous receiver and tells the receive path whether a bit-oriented frame closed with a valid check sequence. Bits reach it one at a time, each with a valid strobe. The bits are already stripped of flags and stuffed zeros. The flag detector, the hunt logic and the host command decoder live outside the block. They deliver their events as pins: a flag pulse, a hunt level, a receiver-enable level and a 2-bit command with a write strobe.

The register returns to its starting value when software asks for it, and also on hardware events. Which hardware events count depends on the mode. In bit-oriented (SDLC-style) mode, hunting and every flag clear the register, so software never has to clear it between frames. In the other synchronous modes only a disabled receiver or the software command clears it. The starting value is all ones in bit-oriented mode and all zeros otherwise. At each flag in bit-oriented mode the block compares the register with the fixed good-frame residue and latches the result.

Top module: `rx_crc_checker`

## Requirements
- R1: While `rst_n` is low, `crc_q` is 0x0000 and `crc_good` is 0.
- R2: In any cycle with `rx_en` low, the next `crc_q` is the preset for the current mode (0xFFFF when `sdlc_mode` is 1, 0x0000 when it is 0), and the next `crc_good` is 0.
- R3: A cycle with `cmd_we` high and `cmd` = 2'b01 loads the mode preset into `crc_q` on the next cycle.
- R4: Command codes 2'b00, 2'b10 and 2'b11 written with `cmd_we` leave `crc_q` unchanged.
- R5: With `sdlc_mode` = 1, `crc_q` is held at 0xFFFF in every cycle after one in which `hunt` is high.
- R6: With `sdlc_mode` = 1, a `flag_seen` pulse loads 0xFFFF into `crc_q` on the next cycle.
- R7: With `sdlc_mode` = 0, `hunt` and `flag_seen` have no effect on `crc_q`.
- R8: When `bit_vld` is high and no reinitialisation applies, the next `crc_q` is (`crc_q` >> 1) XOR (0x8408 if `crc_q`[0] XOR `bit_in` is 1, else 0). Bits enter least significant first. When `bit_vld` is low and no reinitialisation applies, `crc_q` holds.
- R9: A reinitialisation (R2, R3, R5, R6) takes priority over a bit update in the same cycle.
- R10: With `sdlc_mode` = 1, `rx_en` = 1 and `hunt` = 0, a `flag_seen` pulse sets the next `crc_good` to 1 exactly when `crc_q` equals 0xF0B8 in the flag cycle. `crc_good` then holds until the next flag. It is 0 after any cycle with `sdlc_mode` = 0, `rx_en` = 0 or `hunt` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low holds the register at its preset |
| sdlc_mode | input | 1 | 1 = bit-oriented framing, 0 = other synchronous mode |
| hunt | input | 1 | Receiver is searching for sync/flag |
| flag_seen | input | 1 | One-cycle pulse when a flag has been recognised |
| cmd_we | input | 1 | Command write strobe |
| cmd | input | 2 | CRC command code (01 = clear receive CRC) |
| bit_vld | input | 1 | `bit_in` carries a data bit this cycle |
| bit_in | input | 1 | Received data bit |
| crc_q | output | 16 | Running CRC register |
| crc_good | output | 1 | Last closing flag found the good-frame residue |

## Verification
The bench builds the block with its default 16-bit width, CCITT polynomial and presets, so the residue 0xF0B8 is reachable with real frames. It sweeps frame lengths from one to twenty bytes of pseudo-random data. Each frame has a check sequence computed in the bench, and the bench compares the register after every bit and checks the flag verdict. A copy of each frame with one check bit flipped must be rejected. Each reinitialisation source, each command code and the priority of a clear over a same-cycle update are driven in both modes.

// File: rtl/rxcrc_pkg.sv
package rxcrc_pkg;

    typedef enum logic [1:0] {
        CRC_CMD_NOP     = 2'b00,
        CRC_CMD_RX_CLR  = 2'b01,
        CRC_CMD_TX_CLR  = 2'b10,
        CRC_CMD_EOM_CLR = 2'b11
    } crc_cmd_e;

endpackage

// File: rtl/rxcrc_clear_ctl.sv
module rxcrc_clear_ctl
    import rxcrc_pkg::*;
#(
    parameter int              CRC_W       = 16,
    parameter logic [CRC_W-1:0] SDLC_PRESET = '1,
    parameter logic [CRC_W-1:0] SYNC_PRESET = '0
) (
    input  logic             rx_en,
    input  logic             sdlc_mode,
    input  logic             hunt,
    input  logic             flag_seen,
    input  logic             cmd_we,
    input  logic [1:0]       cmd,
    output logic             clear,
    output logic             frame_end,
    output logic [CRC_W-1:0] preset
);

    logic sw_clear;
    logic hw_clear;

    always_comb begin
        sw_clear  = cmd_we && (crc_cmd_e'(cmd) == CRC_CMD_RX_CLR);
        hw_clear  = !rx_en || (sdlc_mode && (hunt || flag_seen));
        clear     = sw_clear || hw_clear;
        frame_end = rx_en && sdlc_mode && !hunt && flag_seen;
        preset    = sdlc_mode ? SDLC_PRESET : SYNC_PRESET;
    end

endmodule

// File: rtl/rxcrc_bit_step.sv
module rxcrc_bit_step #(
    parameter int               CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_out
);

    function automatic logic [CRC_W-1:0] mirror(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int k = 0; k < CRC_W; k++) begin
            r[k] = v[CRC_W-1-k];
        end
        return r;
    endfunction

    localparam logic [CRC_W-1:0] POLY_REFL = mirror(POLY);

    logic fb;
    assign fb = crc_in[0] ^ bit_in;

    for (genvar i = 0; i < CRC_W; i++) begin : g_tap
        if (i == CRC_W - 1) begin : g_top
            assign crc_out[i] = fb & POLY_REFL[i];
        end else begin : g_mid
            assign crc_out[i] = crc_in[i+1] ^ (fb & POLY_REFL[i]);
        end
    end

endmodule

// File: rtl/rx_crc_checker.sv
module rx_crc_checker #(
    parameter int               CRC_W        = 16,
    parameter logic [CRC_W-1:0] POLY         = 16'h1021,
    parameter logic [CRC_W-1:0] SDLC_PRESET  = '1,
    parameter logic [CRC_W-1:0] SYNC_PRESET  = '0,
    parameter logic [CRC_W-1:0] GOOD_RESIDUE = 16'hF0B8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             sdlc_mode,
    input  logic             hunt,
    input  logic             flag_seen,
    input  logic             cmd_we,
    input  logic [1:0]       cmd,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_q,
    output logic             crc_good
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic             good;
    } chk_state_t;

    chk_state_t st_d, st_q;

    logic             clear;
    logic             frame_end;
    logic [CRC_W-1:0] preset;
    logic [CRC_W-1:0] stepped;

    rxcrc_clear_ctl #(
        .CRC_W      (CRC_W),
        .SDLC_PRESET(SDLC_PRESET),
        .SYNC_PRESET(SYNC_PRESET)
    ) u_clr (
        .rx_en    (rx_en),
        .sdlc_mode(sdlc_mode),
        .hunt     (hunt),
        .flag_seen(flag_seen),
        .cmd_we   (cmd_we),
        .cmd      (cmd),
        .clear    (clear),
        .frame_end(frame_end),
        .preset   (preset)
    );

    rxcrc_bit_step #(
        .CRC_W(CRC_W),
        .POLY (POLY)
    ) u_step (
        .crc_in (st_q.crc),
        .bit_in (bit_in),
        .crc_out(stepped)
    );

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.crc = preset;
        end else if (bit_vld) begin
            st_d.crc = stepped;
        end

        if (!rx_en || !sdlc_mode || hunt) begin
            st_d.good = 1'b0;
        end else if (frame_end) begin
            st_d.good = (st_q.crc == GOOD_RESIDUE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_q    = st_q.crc;
    assign crc_good = st_q.good;

endmodule

// File: rtl/rx_crc_checker_sva.sv
module rx_crc_checker_sva #(
    parameter int               CRC_W       = 16,
    parameter logic [CRC_W-1:0] SDLC_PRESET = '1,
    parameter logic [CRC_W-1:0] SYNC_PRESET = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             sdlc_mode,
    input logic             hunt,
    input logic             flag_seen,
    input logic             cmd_we,
    input logic [1:0]       cmd,
    input logic             bit_vld,
    input logic [CRC_W-1:0] crc_q,
    input logic             crc_good
);

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |-> (crc_q == '0 && !crc_good)); // R1

    AST_DISABLED_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (crc_q == ($past(sdlc_mode) ? SDLC_PRESET : SYNC_PRESET)) && !crc_good); // R2

    AST_CMD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd == 2'b01) |=> crc_q == ($past(sdlc_mode) ? SDLC_PRESET : SYNC_PRESET)); // R3

    AST_HUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sdlc_mode && hunt) |=> crc_q == SDLC_PRESET); // R5

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sdlc_mode && flag_seen) |=> crc_q == SDLC_PRESET); // R6

    AST_SYNC_FLAG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sdlc_mode && rx_en && !bit_vld && !(cmd_we && cmd == 2'b01) && (hunt || flag_seen))
        |=> $stable(crc_q)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !bit_vld && !(cmd_we && cmd == 2'b01) && !(sdlc_mode && (hunt || flag_seen)))
        |=> $stable(crc_q)); // R8

    AST_GOOD_NEEDS_SDLC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_good) |-> $past(sdlc_mode && rx_en && flag_seen && !hunt)); // R10

endmodule

bind rx_crc_checker rx_crc_checker_sva #(
    .CRC_W      (CRC_W),
    .SDLC_PRESET(SDLC_PRESET),
    .SYNC_PRESET(SYNC_PRESET)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .sdlc_mode(sdlc_mode),
    .hunt     (hunt),
    .flag_seen(flag_seen),
    .cmd_we   (cmd_we),
    .cmd      (cmd),
    .bit_vld  (bit_vld),
    .crc_q    (crc_q),
    .crc_good (crc_good)
);

// File: tb/sim_rx_crc_checker.sv
module sim_rx_crc_checker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_en, sdlc_mode, hunt, flag_seen, cmd_we, bit_vld, bit_in;
    logic [1:0]  cmd;
    logic [15:0] crc_q;
    logic        crc_good;

    int vecs = 0;
    int errs = 0;
    logic [15:0] model;
    logic [31:0] rng = 32'h1234_5678;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_crc_checker u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sdlc_mode(sdlc_mode),
        .hunt(hunt), .flag_seen(flag_seen), .cmd_we(cmd_we), .cmd(cmd),
        .bit_vld(bit_vld), .bit_in(bit_in), .crc_q(crc_q), .crc_good(crc_good)
    );

    function automatic logic [15:0] ref_step(input logic [15:0] c, input logic b);
        logic [15:0] r;
        r = c >> 1;
        if (c[0] ^ b) r = r ^ 16'h8408;
        return r;
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        hunt = 0; flag_seen = 0; cmd_we = 0; cmd = 2'b00; bit_vld = 0; bit_in = 0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input string tag);
        idle(); bit_vld = 1; bit_in = b;
        tick();
        model = ref_step(model, b);
        chk(tag, crc_q, model);
    endtask

    task automatic run_frame(input int nbytes, input bit corrupt);
        logic [15:0] fcs;
        logic [7:0]  d;
        sdlc_mode = 1; rx_en = 1;
        idle(); hunt = 1; tick(); tick();
        chk("R5 hunt hold", crc_q, 16'hFFFF);
        idle(); flag_seen = 1; tick();
        chk("R6 opening flag", crc_q, 16'hFFFF);
        chk("R10 opening flag not good", crc_good, 0);
        model = 16'hFFFF;
        for (int i = 0; i < nbytes; i++) begin
            rng = next_rng(rng);
            d = rng[7:0];
            for (int k = 0; k < 8; k++) send_bit(d[k], "R8 data bit");
        end
        fcs = ~model;
        if (corrupt) fcs[nbytes % 16] = ~fcs[nbytes % 16];
        for (int k = 0; k < 16; k++) send_bit(fcs[k], "R8 fcs bit");
        if (!corrupt) chk("R10 residue reached", crc_q, 16'hF0B8);
        idle(); flag_seen = 1; tick();
        chk("R10 closing verdict", crc_good, corrupt ? 0 : 1);
        chk("R6 closing flag clears", crc_q, 16'hFFFF);
        idle(); tick(); tick();
        chk("R10 verdict held", crc_good, corrupt ? 0 : 1);
    endtask

    initial begin
        rst_n = 0; rx_en = 0; sdlc_mode = 0; idle();
        tick(); tick();
        chk("R1 reset crc", crc_q, 16'h0000);
        chk("R1 reset good", crc_good, 0);
        rst_n = 1;

        // R2: disabled receiver presets per mode
        sdlc_mode = 1; rx_en = 0; tick();
        chk("R2 disabled sdlc preset", crc_q, 16'hFFFF);
        sdlc_mode = 0; tick();
        chk("R2 disabled sync preset", crc_q, 16'h0000);

        // R8 / R10: frame sweep
        for (int n = 1; n <= 20; n++) begin
            run_frame(n, 0);
            run_frame(n, 1);
        end

        // R2: drop rx_en after a good frame clears verdict
        run_frame(3, 0);
        rx_en = 0; idle(); tick();
        chk("R2 verdict cleared", crc_good, 0);
        rx_en = 1;

        // Non-SDLC mode: preset zeros, hunt/flag ignored (R7)
        sdlc_mode = 0; rx_en = 0; idle(); tick(); rx_en = 1;
        model = 16'h0000;
        for (int k = 0; k < 11; k++) send_bit(k[0] ^ k[2], "R8 sync bit");
        idle(); hunt = 1; tick();
        chk("R7 hunt ignored", crc_q, model);
        idle(); flag_seen = 1; tick();
        chk("R7 flag ignored", crc_q, model);
        chk("R10 good low in sync", crc_good, 0);

        // R8: no-valid cycles hold
        idle(); tick(); tick();
        chk("R8 hold no valid", crc_q, model);

        // R4: other command codes no effect
        for (int c = 0; c < 4; c++) begin
            if (c == 1) continue;
            idle(); cmd_we = 1; cmd = 2'(c); tick();
            chk("R4 other code", crc_q, model);
        end
        // R3: clear command in sync mode
        idle(); cmd_we = 1; cmd = 2'b01; tick();
        chk("R3 clear sync", crc_q, 16'h0000);
        // R3 with cmd_we low: no effect
        model = 16'h0000;
        send_bit(1'b1, "R8 bit");
        idle(); cmd = 2'b01; tick();
        chk("R3 needs strobe", crc_q, model);

        // R9: clear beats same-cycle update
        idle(); cmd_we = 1; cmd = 2'b01; bit_vld = 1; bit_in = 1; tick();
        chk("R9 cmd priority", crc_q, 16'h0000);
        sdlc_mode = 1; idle(); flag_seen = 1; tick();
        model = 16'hFFFF;
        send_bit(1'b0, "R8 bit");
        idle(); cmd_we = 1; cmd = 2'b01; tick();
        chk("R3 clear sdlc", crc_q, 16'hFFFF);
        model = 16'hFFFF;
        send_bit(1'b1, "R8 bit");
        send_bit(1'b0, "R8 bit");
        idle(); flag_seen = 1; bit_vld = 1; bit_in = 1; tick();
        chk("R9 flag priority", crc_q, 16'hFFFF);
        model = 16'hFFFF;
        send_bit(1'b0, "R8 bit");
        idle(); hunt = 1; bit_vld = 1; bit_in = 0; tick();
        chk("R9 hunt priority", crc_q, 16'hFFFF);
        chk("R10 hunt clears good", crc_good, 0);
        model = 16'hFFFF;
        send_bit(1'b1, "R8 bit");
        idle(); rx_en = 0; bit_vld = 1; bit_in = 1; tick();
        chk("R9 disable priority", crc_q, 16'hFFFF);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errs++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule